// File: doc/BRIEF.md
# Quarter-Wave Twiddle Generator

This block produces the rotation factors e^(-j·2πk/2048) for the first half of a 2048-point transform, k = 0 to 1023. It is meant to feed the complex multiplier of a radix-2 split, where a 2048-point FFT is built from two 1024-point FFTs. On each enabled clock it emits one sample pair: the cosine as the real part and the negated sine as the imaginary part. Both are 16-bit signed values, and 32767 stands for 1.0.

Only one quarter of a sine period is kept in a table. It has 512 entries and is computed when the design is elaborated. Two read ports scan this table at the same time, one for the cosine and one for the sine. An index mapper picks the scan direction and decides when to negate. It also supplies the single peak point that the table does not hold.

The index either counts up by itself or is loaded from an input when a start strobe arrives. Results appear one clock after the request and carry a valid flag.

Top module: `twiddle_quarter_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid` is 0 and `out_k`, `out_re` and `out_im` are all 0.
- R2: `out_valid` is 1 in the cycle after a rising clock edge where `en` was 1. It is 0 in the cycle after an edge where `en` was 0.
- R3: At an edge where `en` and `start` are both 1, the index emitted is `k_in`, taken as an unsigned 10-bit value. One cycle later `out_k` shows that index.
- R4: At an edge where `en` is 1 and `start` is 0, the index emitted is the previously emitted index plus 1, wrapping from 1023 to 0. The first index emitted after reset without `start` is 0.
- R5: `out_re` equals round(32767·cos(2π·k/2048)) for the emitted k, as a two's-complement 16-bit value.
- R6: `out_im` equals −round(32767·sin(2π·k/2048)) for the emitted k, as a two's-complement 16-bit value.
- R7: For k = 0 the outputs are `out_re` = 32767 and `out_im` = 0. For k = 512 they are `out_re` = 0 and `out_im` = −32767.
- R8: `out_im` is never positive. `out_re` is positive for k below 512 and negative for k above 512. Neither output ever takes the value −32768.
- R9: At an edge where `en` is 0, `out_k`, `out_re`, `out_im` and the internal sequence position stay unchanged, and `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Emit one sample pair at this edge |
| start | input | 1 | With `en`, take the index from `k_in` instead of the counter |
| k_in | input | 10 | Index loaded on `start` |
| out_valid | output | 1 | Output pair is from the previous edge's request |
| out_k | output | 10 | Index of the current output pair |
| out_re | output | 16 | Cosine, signed, 32767 = 1.0 |
| out_im | output | 16 | Negated sine, signed, 32767 = 1.0 |

## Verification
The assertions assume that `en`, `start` and `k_in` are valid two-state levels at every rising edge. They also assume reset is held for at least one edge before the first request. The stepping property relies on the index continuing from the last emitted value even across idle gaps. The bench meets these conditions by driving all inputs one nanosecond after each edge. It also holds reset for several cycles before driving any requests.

The bench sweeps every index of the half period, both in sequence and across the wrap. It then repeats requests with gaps, issues strobes while `en` is low, and loads indices at the quadrant boundaries.

// File: rtl/twg_pkg.sv
package twg_pkg;

    localparam int  TWG_NPTS = 2048;
    localparam int  TWG_DW   = 16;
    localparam real TWG_PI   = 3.14159265358979323846;

    // Where a port's magnitude comes from: the quarter table or the fixed peak.
    typedef enum logic {
        SRC_TABLE = 1'b0,
        SRC_PEAK  = 1'b1
    } twg_src_e;

    // Per-port control carried alongside the table read.
    typedef struct packed {
        twg_src_e src;
        logic     neg;
    } twg_ctl_t;

    localparam twg_ctl_t TWG_CTL_IDLE = '{src: SRC_TABLE, neg: 1'b0};

    function automatic int twg_amp(input int dw);
        return (1 << (dw - 1)) - 1;
    endfunction

    // Rounded full-scale sine of 2*pi*idx/npts for a first-quadrant angle.
    function automatic int twg_qsin(input int idx, input int npts, input int dw);
        real x;
        real term;
        real acc;
        x    = 2.0 * TWG_PI * real'(idx) / real'(npts);
        term = x;
        acc  = x;
        for (int n = 1; n < 12; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return $rtoi(real'(twg_amp(dw)) * acc + 0.5);
    endfunction

endpackage

// File: rtl/twg_seq.sv
module twg_seq #(
    parameter int KW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          start,
    input  logic [KW-1:0] k_in,
    output logic [KW-1:0] idx
);
    logic [KW-1:0] cnt_q;

    // Index served at this edge: loaded value on a strobe, else the running count.
    always_comb begin
        idx = start ? k_in : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/twg_addr_map.sv
module twg_addr_map
    import twg_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW:0]   idx,
    output logic [AW-1:0] cos_addr,
    output logic [AW-1:0] sin_addr,
    output twg_ctl_t      re_ctl,
    output twg_ctl_t      im_ctl
);
    logic          upper;
    logic [AW-1:0] low;
    logic [AW-1:0] mirror;
    logic          low_zero;

    always_comb begin
        upper    = idx[AW];
        low      = idx[AW-1:0];
        mirror   = '0 - low;
        low_zero = (low == '0);

        // Sine: rises over the first quadrant, then falls back on the mirror scan.
        im_ctl.neg = 1'b1;
        if (upper && low_zero) begin
            im_ctl.src = SRC_PEAK;
            sin_addr   = '0;
        end else begin
            im_ctl.src = SRC_TABLE;
            sin_addr   = upper ? mirror : low;
        end

        // Cosine: mirror scan down from the peak, then a forward scan negated.
        if (!upper && low_zero) begin
            re_ctl.src = SRC_PEAK;
            cos_addr   = '0;
        end else begin
            re_ctl.src = SRC_TABLE;
            cos_addr   = upper ? low : mirror;
        end
        re_ctl.neg = upper;
    end
endmodule

// File: rtl/twg_qrom.sv
module twg_qrom
    import twg_pkg::*;
#(
    parameter int NPTS = 2048,
    parameter int DW   = 16,
    parameter int AW   = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic [DW-1:0] q_a,
    output logic [DW-1:0] q_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        localparam int VAL = twg_qsin(g, NPTS, DW);
        assign tbl[g] = DW'(VAL);
    end

    // Two independent registered read ports over the same contents.
    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else if (rd_en) begin
            q_a <= tbl[addr_a];
            q_b <= tbl[addr_b];
        end
    end
endmodule

// File: rtl/twg_sign_apply.sv
module twg_sign_apply
    import twg_pkg::*;
#(
    parameter int DW = 16
) (
    input  twg_ctl_t             ctl,
    input  logic        [DW-1:0] rom_q,
    output logic signed [DW-1:0] val
);
    localparam logic [DW-1:0] PEAK = DW'(twg_amp(DW));

    logic [DW-1:0] mag;

    always_comb begin
        mag = (ctl.src == SRC_PEAK) ? PEAK : rom_q;
        val = ctl.neg ? $signed('0 - mag) : $signed(mag);
    end
endmodule

// File: rtl/twiddle_quarter_gen.sv
module twiddle_quarter_gen
    import twg_pkg::*;
#(
    parameter int NPTS = TWG_NPTS,
    parameter int DW   = TWG_DW
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              en,
    input  logic                              start,
    input  logic        [$clog2(NPTS/2)-1:0]  k_in,
    output logic                              out_valid,
    output logic        [$clog2(NPTS/2)-1:0]  out_k,
    output logic signed [DW-1:0]              out_re,
    output logic signed [DW-1:0]              out_im
);
    localparam int KW = $clog2(NPTS / 2);
    localparam int AW = $clog2(NPTS / 4);

    logic [KW-1:0] idx;
    logic [AW-1:0] cos_addr;
    logic [AW-1:0] sin_addr;
    twg_ctl_t      re_ctl;
    twg_ctl_t      im_ctl;
    twg_ctl_t      re_ctl_q;
    twg_ctl_t      im_ctl_q;
    logic [DW-1:0] cos_q;
    logic [DW-1:0] sin_q;

    twg_seq #(.KW(KW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .start (start),
        .k_in  (k_in),
        .idx   (idx)
    );

    twg_addr_map #(.AW(AW)) u_map (
        .idx      (idx),
        .cos_addr (cos_addr),
        .sin_addr (sin_addr),
        .re_ctl   (re_ctl),
        .im_ctl   (im_ctl)
    );

    twg_qrom #(.NPTS(NPTS), .DW(DW), .AW(AW)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (en),
        .addr_a (cos_addr),
        .addr_b (sin_addr),
        .q_a    (cos_q),
        .q_b    (sin_q)
    );

    // Control and index travel with the table read so they stay aligned.
    always_ff @(posedge clk) begin
        if (rst) begin
            re_ctl_q  <= TWG_CTL_IDLE;
            im_ctl_q  <= TWG_CTL_IDLE;
            out_k     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= en;
            if (en) begin
                re_ctl_q <= re_ctl;
                im_ctl_q <= im_ctl;
                out_k    <= idx;
            end
        end
    end

    twg_sign_apply #(.DW(DW)) u_re (
        .ctl   (re_ctl_q),
        .rom_q (cos_q),
        .val   (out_re)
    );

    twg_sign_apply #(.DW(DW)) u_im (
        .ctl   (im_ctl_q),
        .rom_q (sin_q),
        .val   (out_im)
    );
endmodule

// File: rtl/twg_chk.sv
module twg_chk #(
    parameter int NPTS = 2048,
    parameter int DW   = 16
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             en,
    input logic                             start,
    input logic        [$clog2(NPTS/2)-1:0] k_in,
    input logic                             out_valid,
    input logic        [$clog2(NPTS/2)-1:0] out_k,
    input logic signed [DW-1:0]             out_re,
    input logic signed [DW-1:0]             out_im
);
    localparam int KW = $clog2(NPTS / 2);
    localparam logic [KW-1:0]        QTR   = KW'(NPTS / 4);
    localparam logic signed [DW-1:0] AMP   = DW'((1 << (DW - 1)) - 1);
    localparam logic signed [DW-1:0] MINV  = {1'b1, {(DW-1){1'b0}}};

    logic seen_q;
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_q | out_valid;
    end
    assign seen = seen_q | out_valid;

    // R2: valid tracks the request one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        en |=> out_valid);
    a_r2_idle_invalid: assert property (@(posedge clk) disable iff (rst)
        !en |=> !out_valid);

    // R3: strobe loads the index
    a_r3_load_index: assert property (@(posedge clk) disable iff (rst)
        (en && start) |=> (out_k == $past(k_in)));

    // R4: free-running step with wrap
    a_r4_step_index: assert property (@(posedge clk) disable iff (rst)
        (en && !start && seen) |=> (out_k == KW'($past(out_k) + 1'b1)));

    // R7: fixed points of the half period
    a_r7_peak_cos: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_k == '0) |-> (out_re == AMP && out_im == '0));
    a_r7_peak_sin: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_k == QTR) |-> (out_re == '0 && out_im == -AMP));

    // R8: sign and range of each component
    a_r8_im_nonpos: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_im <= 0 && out_im != MINV));
    a_r8_re_pos: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_k < QTR) |-> (out_re > 0));
    a_r8_re_neg: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_k > QTR) |-> (out_re < 0 && out_re != MINV));

    // R9: idle edges leave the outputs alone
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(out_k) && $stable(out_re) && $stable(out_im)));
endmodule

bind twiddle_quarter_gen twg_chk #(.NPTS(NPTS), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .start     (start),
    .k_in      (k_in),
    .out_valid (out_valid),
    .out_k     (out_k),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/twiddle_quarter_gen_tb.sv
`timescale 1ns/1ps
module twiddle_quarter_gen_tb;
    localparam int  NPTS = 2048;
    localparam int  HALF = NPTS / 2;
    localparam int  AMPI = 32767;
    localparam real PI   = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  k_in = '0;
    logic        out_valid;
    logic [9:0]  out_k;
    logic signed [15:0] out_re;
    logic signed [15:0] out_im;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int  m_cnt = 0;
    int  m_k = 0;
    bit  m_emitted = 1'b0;
    bit  m_valid = 1'b0;

    always #2 clk = ~clk;

    twiddle_quarter_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .start     (start),
        .k_in      (k_in),
        .out_valid (out_valid),
        .out_k     (out_k),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int exp_re(input int k);
        return rnd(real'(AMPI) * $cos(2.0 * PI * real'(k) / real'(NPTS)));
    endfunction

    function automatic int exp_im(input int k);
        return -rnd(real'(AMPI) * $sin(2.0 * PI * real'(k) / real'(NPTS)));
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, expv, $time);
        end
    endtask

    // One clock: drive, let the edge pass, compare against the model.
    task automatic cyc(input bit e, input bit s, input int k);
        int er;
        int ei;
        string rq;
        en    = e;
        start = s;
        k_in  = 10'(k);
        @(posedge clk);
        #1;
        if (e) begin
            m_k       = s ? k : m_cnt;
            m_cnt     = (m_k + 1) % HALF;
            m_emitted = 1'b1;
            m_valid   = 1'b1;
        end else begin
            m_valid = 1'b0;
        end
        er = m_emitted ? exp_re(m_k) : 0;
        ei = m_emitted ? exp_im(m_k) : 0;
        check("R2 valid", int'(out_valid), int'(m_valid));
        if (!e) begin
            check("R9 hold k", int'(out_k), m_k);
            check("R9 hold re", int'(out_re), er);
            check("R9 hold im", int'(out_im), ei);
        end else begin
            rq = s ? "R3 loaded k" : "R4 stepped k";
            check(rq, int'(out_k), m_k);
            rq = (m_k == 0 || m_k == HALF / 2) ? "R7 R5 re" : "R5 re";
            check(rq, int'(out_re), er);
            rq = (m_k == 0 || m_k == HALF / 2) ? "R7 R6 im" : "R6 im";
            check(rq, int'(out_im), ei);
            check("R8 im not positive", int'(out_im > 0), 0);
            check("R8 no most-negative", int'(out_re == -32768 || out_im == -32768), 0);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset k", int'(out_k), 0);
        check("R1 reset re", int'(out_re), 0);
        check("R1 reset im", int'(out_im), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 post-reset valid", int'(out_valid), 0);
        check("R1 post-reset re", int'(out_re), 0);

        // R4: first emission after reset is index 0; full sweep plus wrap
        for (int i = 0; i < HALF + 8; i++) cyc(1'b1, 1'b0, 0);

        // R2 R9: gaps, and strobes with en low are ignored
        for (int i = 0; i < 40; i++) cyc(i % 2 == 0, 1'b0, 0);
        cyc(1'b0, 1'b1, 700);
        cyc(1'b0, 1'b1, 300);
        cyc(1'b1, 1'b0, 0);

        // R3 R7 R8: loads around the quadrant boundaries and the wrap
        cyc(1'b1, 1'b1, 511); cyc(1'b1, 1'b0, 0); cyc(1'b1, 1'b0, 0);
        cyc(1'b1, 1'b1, 0);
        cyc(1'b1, 1'b1, 1023); cyc(1'b1, 1'b0, 0); cyc(1'b1, 1'b0, 0);
        cyc(1'b1, 1'b1, 513); cyc(1'b0, 1'b0, 0); cyc(1'b1, 1'b0, 0);
        cyc(1'b1, 1'b1, 256); cyc(1'b1, 1'b1, 768); cyc(1'b1, 1'b1, 512);

        // Second sweep with irregular gaps from a loaded start
        cyc(1'b1, 1'b1, 900);
        for (int i = 0; i < 600; i++) cyc((i % 5) != 3, 1'b0, 0);

        // Reset mid-stream
        rst = 1'b1;
        en  = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset again valid", int'(out_valid), 0);
        check("R1 reset again k", int'(out_k), 0);
        check("R1 reset again re", int'(out_re), 0);
        rst = 1'b0;
        m_cnt = 0; m_k = 0; m_emitted = 1'b0; m_valid = 1'b0;
        cyc(1'b0, 1'b0, 0);
        cyc(1'b1, 1'b0, 0);
        cyc(1'b1, 1'b0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule